// File: doc/BRIEF.md
# Timer control register bank

This block is the software-facing register file of a time-of-day timer subsystem. A host reaches it over a plain 32-bit register bus: a 12-bit byte address, write data, a write strobe, a read strobe and a registered read-data return. The block turns host writes into configuration levels, one-cycle control pulses and load values for the timer logic. The timer arithmetic and the external time bus alignment logic sit outside and connect only through ports.

Each register bit has one access type. Configuration and load values are read-write. Trigger bits pulse when written with 1, ignore 0 and always read back 0. The pulse-per-second interrupt status is cleared by writing 1 to it. The clock-period staging words are write-only. Snapshot words are read-only. A single snapshot trigger captures the system timer, the external bus seconds and every enabled port timer on the same clock edge, so that a multi-word value read back afterwards is consistent. A port timer is 48-bit seconds plus 30-bit nanoseconds.

The bus has no handshake. A write takes effect on the clock edge where `bus_wr` is high. A read strobe loads `bus_rdata` on its edge, and the value holds until the next read. Reads have no side effects.

Top module: `tod_csr_bank`

## Requirements
- R1: The configuration word at 0x000 is read-write with reset value 0. Bit 0 drives `cfg_sys_en`, bit 1 drives `cfg_bus_en`, bits 3:2 drive `cfg_ovr_mode` and bits 4+p drive `cfg_port_en[p]`. All bits above 3+NPORT read 0.
- R2: Writing a word with bit 0 set to 0x004 raises `snap_pulse` for the one cycle after that write edge. A write with bit 0 clear raises no pulse. Address 0x004 reads 0.
- R3: On the write edge of a snapshot trigger, the block captures `sys_time_i`, `bus_sec_i` and the TX and RX time of each port whose enable bit is set. The snapshot of a disabled port keeps its previous value.
- R4: Snapshot words do not change with their inputs between triggers. The system snapshot reads at 0x100 (seconds 31:0), 0x104 (seconds 47:32) and 0x108 (nanoseconds). The bus seconds read at 0x120 (bits 31:0) and 0x124 (bits 47:32). Port p has a window at 0x200+p*0x80. In that window the TX time reads at +0x14 (ns), +0x18 and +0x1C (seconds), and the RX time reads at +0x34, +0x38 and +0x3C.
- R5: `pps_evt` sets the interrupt status bit (0x00C bit 0). Writing 1 to that bit clears it and writing 0 leaves it unchanged. When a set and a clear fall on the same cycle, the set wins.
- R6: `irq` is high exactly while the status bit and the enable bit (0x008 bit 0, read-write) are both 1.
- R7: At 0x01C, a written bit 0 pulses `load_time_pulse` and a written bit 1 pulses `load_ofs_pulse`, each for one cycle. The address reads 0.
- R8: The load values are read-write and drive their outputs. Seconds occupy 0x010 (31:0) and 0x014 (47:32). Nanoseconds occupy 0x018 (29:0). Offset seconds occupy 0x028 and 0x02C, and offset nanoseconds occupy 0x030. Unused upper bits read 0.
- R9: The period words at 0x130 (low) and 0x134 (high) are write-only and read 0. A write to the high word sets `sys_period` to {high, last low} and pulses `period_commit` for one cycle. A low write alone leaves `sys_period` unchanged.
- R10: Writes to read-only or unmapped addresses change nothing. Unmapped addresses read 0.
- R11: After reset, every output and every readable register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| cfg_sys_en | output | 1 | System timer enable |
| cfg_bus_en | output | 1 | External time bus enable |
| cfg_ovr_mode | output | 2 | Overwrite mode select |
| cfg_port_en | output | NPORT | Per-port timer enables |
| snap_pulse | output | 1 | Snapshot trigger pulse |
| load_time_pulse | output | 1 | Software time load pulse |
| load_ofs_pulse | output | 1 | Offset load pulse |
| period_commit | output | 1 | Period update pulse |
| sw_sec | output | 48 | Seconds load value |
| sw_ns | output | 30 | Nanoseconds load value |
| ofs_sec | output | 48 | Signed seconds offset |
| ofs_ns | output | 30 | Signed nanoseconds offset |
| sys_period | output | 64 | Committed system clock period |
| pps_evt | input | 1 | Pulse-per-second event |
| irq | output | 1 | Interrupt request |
| sys_time_i | input | 78 | System timer {seconds, ns} |
| bus_sec_i | input | 48 | External bus seconds |
| port_tx_time_i | input | NPORT*78 | TX timers, port p at bits p*78 upward |
| port_rx_time_i | input | NPORT*78 | RX timers, same packing |

## Verification
The bench goes after these corner cases:

- A pulse-per-second event in the same cycle as a clear write. A design that gave the clear priority would lose the event and leave `irq` low.
- A zero written to a trigger or status bit. A design that decoded the strobe without looking at the data would pulse anyway or drop the status.
- Snapshot inputs that change on every cycle, and a port that was disabled at the moment of a trigger. A block that read its inputs live, or captured every port, would return values different from the frozen ones.
- Writes to read-only snapshot addresses, unmapped addresses and reserved configuration bits. These must leave state and read-back untouched.
- Reads of the write-only period words. These must return 0.

// File: rtl/tod_csr_pkg.sv
package tod_csr_pkg;
  localparam int SEC_W = 48;
  localparam int NS_W  = 30;
  localparam int TOD_W = SEC_W + NS_W;
  localparam int DW    = 32;
  localparam int AW    = 12;

  localparam logic [AW-1:0] A_CFG   = 12'h000;
  localparam logic [AW-1:0] A_SNAP  = 12'h004;
  localparam logic [AW-1:0] A_IEN   = 12'h008;
  localparam logic [AW-1:0] A_IST   = 12'h00C;
  localparam logic [AW-1:0] A_SWS0  = 12'h010;
  localparam logic [AW-1:0] A_SWS1  = 12'h014;
  localparam logic [AW-1:0] A_SWNS  = 12'h018;
  localparam logic [AW-1:0] A_LOAD  = 12'h01C;
  localparam logic [AW-1:0] A_OFS0  = 12'h028;
  localparam logic [AW-1:0] A_OFS1  = 12'h02C;
  localparam logic [AW-1:0] A_OFSNS = 12'h030;
  localparam logic [AW-1:0] A_SYS0  = 12'h100;
  localparam logic [AW-1:0] A_SYS1  = 12'h104;
  localparam logic [AW-1:0] A_SYSNS = 12'h108;
  localparam logic [AW-1:0] A_BUS0  = 12'h120;
  localparam logic [AW-1:0] A_BUS1  = 12'h124;
  localparam logic [AW-1:0] A_PER0  = 12'h130;
  localparam logic [AW-1:0] A_PER1  = 12'h134;
  localparam logic [AW-1:0] A_PORT  = 12'h200;

  // offsets inside one 128-byte port window
  localparam logic [6:0] P_TXNS = 7'h14;
  localparam logic [6:0] P_TXS0 = 7'h18;
  localparam logic [6:0] P_TXS1 = 7'h1C;
  localparam logic [6:0] P_RXNS = 7'h34;
  localparam logic [6:0] P_RXS0 = 7'h38;
  localparam logic [6:0] P_RXS1 = 7'h3C;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_t;

  // 0: seconds low word, 1: seconds high bits, 2: nanoseconds
  function automatic logic [DW-1:0] tod_word(tod_t t, logic [1:0] sel);
    case (sel)
      2'd0:    return t.sec[31:0];
      2'd1:    return {{(DW-SEC_W+32){1'b0}}, t.sec[SEC_W-1:32]};
      default: return {{(DW-NS_W){1'b0}}, t.ns};
    endcase
  endfunction
endpackage

// File: rtl/tod_csr_irq.sv
module tod_csr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_evt,
  input  logic en_wr,
  input  logic en_val,
  input  logic clr_wr,
  input  logic clr_bit,
  output logic en_q,
  output logic stat_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_val;
      // a new event outranks a simultaneous acknowledge
      if (pps_evt)                stat_q <= 1'b1;
      else if (clr_wr && clr_bit) stat_q <= 1'b0;
    end
  end

  assign irq = stat_q & en_q;
endmodule

// File: rtl/tod_csr_snap.sv
module tod_csr_snap
  import tod_csr_pkg::*;
#(
  parameter int NPORT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic [NPORT-1:0]       port_en,
  input  tod_t                   sys_in,
  input  logic [SEC_W-1:0]       bus_in,
  input  logic [NPORT*TOD_W-1:0] tx_in,
  input  logic [NPORT*TOD_W-1:0] rx_in,
  input  logic [AW-1:0]          rd_addr,
  output logic                   rd_hit,
  output logic [DW-1:0]          rd_val
);
  localparam logic [4:0] PBASE = 5'(A_PORT >> 7);

  tod_t             sys_q;
  logic [SEC_W-1:0] bus_q;
  tod_t             tx_q [NPORT];
  tod_t             rx_q [NPORT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_q <= '0;
      bus_q <= '0;
    end else if (take) begin
      sys_q <= sys_in;
      bus_q <= bus_in;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tx_q[p] <= '0;
        rx_q[p] <= '0;
      end else if (take && port_en[p]) begin
        tx_q[p] <= tx_in[p*TOD_W +: TOD_W];
        rx_q[p] <= rx_in[p*TOD_W +: TOD_W];
      end
    end
  end

  logic [4:0] pidx;
  tod_t       tx_sel, rx_sel;
  logic       pvalid;

  always_comb begin
    pidx   = rd_addr[11:7] - PBASE;
    pvalid = 1'b0;
    tx_sel = '0;
    rx_sel = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (rd_addr >= A_PORT && pidx == 5'(p)) begin
        pvalid = 1'b1;
        tx_sel = tx_q[p];
        rx_sel = rx_q[p];
      end
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    case (rd_addr)
      A_SYS0:  rd_val = tod_word(sys_q, 2'd0);
      A_SYS1:  rd_val = tod_word(sys_q, 2'd1);
      A_SYSNS: rd_val = tod_word(sys_q, 2'd2);
      A_BUS0:  rd_val = bus_q[31:0];
      A_BUS1:  rd_val = {{(DW-SEC_W+32){1'b0}}, bus_q[SEC_W-1:32]};
      default: begin
        rd_hit = pvalid;
        if (pvalid) begin
          case (rd_addr[6:0])
            P_TXS0:  rd_val = tod_word(tx_sel, 2'd0);
            P_TXS1:  rd_val = tod_word(tx_sel, 2'd1);
            P_TXNS:  rd_val = tod_word(tx_sel, 2'd2);
            P_RXS0:  rd_val = tod_word(rx_sel, 2'd0);
            P_RXS1:  rd_val = tod_word(rx_sel, 2'd1);
            P_RXNS:  rd_val = tod_word(rx_sel, 2'd2);
            default: rd_val = '0;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/tod_csr_bank.sv
module tod_csr_bank
  import tod_csr_pkg::*;
#(
  parameter int NPORT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [11:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  output logic [31:0]            bus_rdata,
  output logic                   cfg_sys_en,
  output logic                   cfg_bus_en,
  output logic [1:0]             cfg_ovr_mode,
  output logic [NPORT-1:0]       cfg_port_en,
  output logic                   snap_pulse,
  output logic                   load_time_pulse,
  output logic                   load_ofs_pulse,
  output logic                   period_commit,
  output logic [47:0]            sw_sec,
  output logic [29:0]            sw_ns,
  output logic [47:0]            ofs_sec,
  output logic [29:0]            ofs_ns,
  output logic [63:0]            sys_period,
  input  logic                   pps_evt,
  output logic                   irq,
  input  logic [77:0]            sys_time_i,
  input  logic [47:0]            bus_sec_i,
  input  logic [NPORT*78-1:0]    port_tx_time_i,
  input  logic [NPORT*78-1:0]    port_rx_time_i
);
  localparam int CFG_W = 4 + NPORT;

  logic [CFG_W-1:0] cfg_q;
  logic [31:0]      per_lo_q;
  logic             irq_en_w, irq_stat_w;
  logic             snap_hit;
  logic [DW-1:0]    snap_val;
  logic [DW-1:0]    rd_mux;

  function automatic logic wr_at(logic [AW-1:0] a);
    return bus_wr && (bus_addr == a);
  endfunction

  logic snap_take;
  assign snap_take = wr_at(A_SNAP) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q           <= '0;
      sw_sec          <= '0;
      sw_ns           <= '0;
      ofs_sec         <= '0;
      ofs_ns          <= '0;
      per_lo_q        <= '0;
      sys_period      <= '0;
      snap_pulse      <= 1'b0;
      load_time_pulse <= 1'b0;
      load_ofs_pulse  <= 1'b0;
      period_commit   <= 1'b0;
      bus_rdata       <= '0;
    end else begin
      if (wr_at(A_CFG))   cfg_q          <= bus_wdata[CFG_W-1:0];
      if (wr_at(A_SWS0))  sw_sec[31:0]   <= bus_wdata;
      if (wr_at(A_SWS1))  sw_sec[47:32]  <= bus_wdata[15:0];
      if (wr_at(A_SWNS))  sw_ns          <= bus_wdata[29:0];
      if (wr_at(A_OFS0))  ofs_sec[31:0]  <= bus_wdata;
      if (wr_at(A_OFS1))  ofs_sec[47:32] <= bus_wdata[15:0];
      if (wr_at(A_OFSNS)) ofs_ns         <= bus_wdata[29:0];
      if (wr_at(A_PER0))  per_lo_q       <= bus_wdata;
      if (wr_at(A_PER1))  sys_period     <= {bus_wdata, per_lo_q};
      snap_pulse      <= snap_take;
      load_time_pulse <= wr_at(A_LOAD) && bus_wdata[0];
      load_ofs_pulse  <= wr_at(A_LOAD) && bus_wdata[1];
      period_commit   <= wr_at(A_PER1);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign cfg_sys_en   = cfg_q[0];
  assign cfg_bus_en   = cfg_q[1];
  assign cfg_ovr_mode = cfg_q[3:2];
  assign cfg_port_en  = cfg_q[CFG_W-1:4];

  tod_csr_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .pps_evt (pps_evt),
    .en_wr   (wr_at(A_IEN)),
    .en_val  (bus_wdata[0]),
    .clr_wr  (wr_at(A_IST)),
    .clr_bit (bus_wdata[0]),
    .en_q    (irq_en_w),
    .stat_q  (irq_stat_w),
    .irq     (irq)
  );

  tod_csr_snap #(.NPORT(NPORT)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (snap_take),
    .port_en (cfg_port_en),
    .sys_in  (sys_time_i),
    .bus_in  (bus_sec_i),
    .tx_in   (port_tx_time_i),
    .rx_in   (port_rx_time_i),
    .rd_addr (bus_addr),
    .rd_hit  (snap_hit),
    .rd_val  (snap_val)
  );

  // trigger, write-only and unmapped addresses all fall to zero
  always_comb begin
    case (bus_addr)
      A_CFG:   rd_mux = DW'(cfg_q);
      A_IEN:   rd_mux = {31'd0, irq_en_w};
      A_IST:   rd_mux = {31'd0, irq_stat_w};
      A_SWS0:  rd_mux = sw_sec[31:0];
      A_SWS1:  rd_mux = {16'd0, sw_sec[47:32]};
      A_SWNS:  rd_mux = {2'd0, sw_ns};
      A_OFS0:  rd_mux = ofs_sec[31:0];
      A_OFS1:  rd_mux = {16'd0, ofs_sec[47:32]};
      A_OFSNS: rd_mux = {2'd0, ofs_ns};
      default: rd_mux = snap_hit ? snap_val : '0;
    endcase
  end
endmodule

// File: rtl/tod_csr_sva.sv
module tod_csr_sva
  import tod_csr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic [1:0]  wbits,
  input logic        bus_wr,
  input logic        snap_pulse,
  input logic        load_time_pulse,
  input logic        load_ofs_pulse,
  input logic        period_commit,
  input logic        pps_evt,
  input logic        irq,
  input logic        irq_en,
  input logic        irq_stat,
  input logic        cfg_sys_en,
  input logic [1:0]  cfg_ovr_mode
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_snap_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && snap_pulse) |-> $past(bus_wr && bus_addr == A_SNAP && wbits[0]));

  assert_ltime_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && load_time_pulse) |-> $past(bus_wr && bus_addr == A_LOAD && wbits[0]));

  assert_lofs_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && load_ofs_pulse) |-> $past(bus_wr && bus_addr == A_LOAD && wbits[1]));

  assert_commit_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && period_commit) |-> $past(bus_wr && bus_addr == A_PER1));

  assert_pps_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pps_evt |=> irq_stat);

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(bus_wr && bus_addr == A_CFG)) |=> ($stable(cfg_sys_en) && $stable(cfg_ovr_mode)));
endmodule

bind tod_csr_bank tod_csr_sva u_sva (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_addr        (bus_addr),
  .wbits           (bus_wdata[1:0]),
  .bus_wr          (bus_wr),
  .snap_pulse      (snap_pulse),
  .load_time_pulse (load_time_pulse),
  .load_ofs_pulse  (load_ofs_pulse),
  .period_commit   (period_commit),
  .pps_evt         (pps_evt),
  .irq             (irq),
  .irq_en          (irq_en_w),
  .irq_stat        (irq_stat_w),
  .cfg_sys_en      (cfg_sys_en),
  .cfg_ovr_mode    (cfg_ovr_mode)
);

// File: tb/tod_csr_bank_bench.sv
module tod_csr_bank_bench;
  localparam int NP = 4;
  localparam int TW = 78;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]      bus_rdata;
  logic             cfg_sys_en, cfg_bus_en;
  logic [1:0]       cfg_ovr_mode;
  logic [NP-1:0]    cfg_port_en;
  logic             snap_pulse, load_time_pulse, load_ofs_pulse, period_commit;
  logic [47:0]      sw_sec, ofs_sec;
  logic [29:0]      sw_ns, ofs_ns;
  logic [63:0]      sys_period;
  logic             pps_evt = 1'b0;
  logic             irq;
  logic [TW-1:0]    sys_time_i = '0;
  logic [47:0]      bus_sec_i = '0;
  logic [NP*TW-1:0] tx_i = '0, rx_i = '0;

  tod_csr_bank #(.NPORT(NP)) u_tod_csr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cfg_sys_en(cfg_sys_en), .cfg_bus_en(cfg_bus_en), .cfg_ovr_mode(cfg_ovr_mode),
    .cfg_port_en(cfg_port_en), .snap_pulse(snap_pulse), .load_time_pulse(load_time_pulse),
    .load_ofs_pulse(load_ofs_pulse), .period_commit(period_commit),
    .sw_sec(sw_sec), .sw_ns(sw_ns), .ofs_sec(ofs_sec), .ofs_ns(ofs_ns),
    .sys_period(sys_period), .pps_evt(pps_evt), .irq(irq),
    .sys_time_i(sys_time_i), .bus_sec_i(bus_sec_i),
    .port_tx_time_i(tx_i), .port_rx_time_i(rx_i)
  );

  int total = 0, bad = 0;

  // reference model
  logic [31:0] m_cfg;
  logic        m_en, m_st;
  logic [47:0] m_sws, m_os;
  logic [29:0] m_swns, m_ons;
  logic [31:0] m_perlo;
  logic [63:0] m_per;
  logic [TW-1:0] m_sys;
  logic [47:0]   m_bus;
  logic [TW-1:0] m_tx [NP];
  logic [TW-1:0] m_rx [NP];

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(logic [TW-1:0] t, int sel);
    logic [47:0] s = t[77:30];
    if (sel == 0) return s[31:0];
    if (sel == 1) return {16'd0, s[47:32]};
    return {2'd0, t[29:0]};
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    case (a)
      12'h000: return m_cfg & 32'h0000_00FF;
      12'h008: return {31'd0, m_en};
      12'h00C: return {31'd0, m_st};
      12'h010: return m_sws[31:0];
      12'h014: return {16'd0, m_sws[47:32]};
      12'h018: return {2'd0, m_swns};
      12'h028: return m_os[31:0];
      12'h02C: return {16'd0, m_os[47:32]};
      12'h030: return {2'd0, m_ons};
      12'h100: return word_of(m_sys, 0);
      12'h104: return word_of(m_sys, 1);
      12'h108: return word_of(m_sys, 2);
      12'h120: return m_bus[31:0];
      12'h124: return {16'd0, m_bus[47:32]};
      default: begin
        int p;
        if (a < 12'h200) return 32'd0;
        p = int'(a >> 7) - 4;
        if (p >= NP) return 32'd0;
        case (a[6:0])
          7'h18: return word_of(m_tx[p], 0);
          7'h1C: return word_of(m_tx[p], 1);
          7'h14: return word_of(m_tx[p], 2);
          7'h38: return word_of(m_rx[p], 0);
          7'h3C: return word_of(m_rx[p], 1);
          7'h34: return word_of(m_rx[p], 2);
          default: return 32'd0;
        endcase
      end
    endcase
  endfunction

  task automatic shuffle_inputs();
    sys_time_i = {$urandom, $urandom, $urandom};
    bus_sec_i  = {$urandom, $urandom};
    for (int i = 0; i < NP; i++) begin
      tx_i[i*TW +: TW] = {$urandom, $urandom, $urandom};
      rx_i[i*TW +: TW] = {$urandom, $urandom, $urandom};
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic pps);
    logic e_snap, e_lt, e_lo, e_pc;
    @(negedge clk);
    shuffle_inputs();
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; pps_evt = pps;
    e_snap = (a == 12'h004) && d[0];
    e_lt   = (a == 12'h01C) && d[0];
    e_lo   = (a == 12'h01C) && d[1];
    e_pc   = (a == 12'h134);
    if (e_snap) begin
      m_sys = sys_time_i; m_bus = bus_sec_i;
      for (int i = 0; i < NP; i++)
        if (m_cfg[4+i]) begin
          m_tx[i] = tx_i[i*TW +: TW];
          m_rx[i] = rx_i[i*TW +: TW];
        end
    end
    case (a)
      12'h000: m_cfg = d & 32'h0000_00FF;
      12'h008: m_en = d[0];
      12'h010: m_sws[31:0] = d;
      12'h014: m_sws[47:32] = d[15:0];
      12'h018: m_swns = d[29:0];
      12'h028: m_os[31:0] = d;
      12'h02C: m_os[47:32] = d[15:0];
      12'h030: m_ons = d[29:0];
      12'h130: m_perlo = d;
      12'h134: m_per = {d, m_perlo};
      default: ;
    endcase
    if (pps) m_st = 1'b1;
    else if (a == 12'h00C && d[0]) m_st = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; pps_evt = 1'b0;
    check(snap_pulse == e_snap, "R2 snap_pulse", 64'(snap_pulse), 64'(e_snap));
    check(load_time_pulse == e_lt, "R7 load_time_pulse", 64'(load_time_pulse), 64'(e_lt));
    check(load_ofs_pulse == e_lo, "R7 load_ofs_pulse", 64'(load_ofs_pulse), 64'(e_lo));
    check(period_commit == e_pc, "R9 period_commit", 64'(period_commit), 64'(e_pc));
    check(sys_period == m_per, "R9 sys_period", sys_period, m_per);
    check(irq == (m_st & m_en), "R6 irq", 64'(irq), 64'(m_st & m_en));
    check({cfg_port_en, cfg_ovr_mode, cfg_bus_en, cfg_sys_en} == m_cfg[7:0], "R1 cfg outputs",
          64'({cfg_port_en, cfg_ovr_mode, cfg_bus_en, cfg_sys_en}), 64'(m_cfg[7:0]));
    check(sw_sec == m_sws && sw_ns == m_swns && ofs_sec == m_os && ofs_ns == m_ons,
          "R8 load value outputs", {sw_sec[31:0], sw_ns[29:0], 2'b0}, {m_sws[31:0], m_swns, 2'b0});
    @(negedge clk);
    check(!snap_pulse && !load_time_pulse && !load_ofs_pulse && !period_commit,
          "R2 pulses last one cycle", 64'({snap_pulse, load_time_pulse, load_ofs_pulse, period_commit}), 64'd0);
  endtask

  task automatic do_read(input logic [11:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    shuffle_inputs();
    bus_addr = a; bus_rd = 1'b1;
    e = exp_read(a);
    @(negedge clk);
    bus_rd = 1'b0;
    check(bus_rdata == e, req, 64'(bus_rdata), 64'(e));
  endtask

  function automatic logic [11:0] pick_addr(int unsigned r, int unsigned s);
    logic [11:0] fixed [20] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                                12'h018, 12'h01C, 12'h028, 12'h02C, 12'h030, 12'h100,
                                12'h104, 12'h108, 12'h120, 12'h124, 12'h130, 12'h134,
                                12'h034, 12'h0FC};
    logic [6:0] offs [7] = '{7'h14, 7'h18, 7'h1C, 7'h34, 7'h38, 7'h3C, 7'h20};
    if (r % 28 < 20) return fixed[r % 28];
    return 12'h200 + 12'((s % 5) * 128) + 12'(offs[(s / 5) % 7]);
  endfunction

  logic done = 1'b0;

  initial begin
    void'($urandom(32'd2024));
    m_cfg = '0; m_en = 0; m_st = 0; m_sws = '0; m_os = '0; m_swns = '0; m_ons = '0;
    m_perlo = '0; m_per = '0; m_sys = '0; m_bus = '0;
    for (int i = 0; i < NP; i++) begin m_tx[i] = '0; m_rx[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(bus_rdata == 0 && !irq && !snap_pulse && sys_period == 0 && cfg_port_en == 0,
          "R11 reset outputs", 64'(bus_rdata), 64'd0);
    do_read(12'h000, "R11 cfg reset");
    do_read(12'h100, "R11 snapshot reset");
    // R1 reserved bits mask
    do_write(12'h000, 32'hFFFF_FFFF, 1'b0);
    do_read(12'h000, "R1 reserved cfg bits read 0");
    do_write(12'h000, 32'h0000_005A, 1'b0);
    do_read(12'h000, "R1 cfg readback");
    // R2 zero write: no pulse; trigger reads 0
    do_write(12'h004, 32'hFFFF_FFFE, 1'b0);
    do_read(12'h004, "R2 trigger reads 0");
    // R3 snapshot with ports 0 and 2 enabled (cfg 0x5A: ports bits 7:4 = 0101)
    do_write(12'h004, 32'h1, 1'b0);
    do_read(12'h100, "R3 sys sec lo");
    do_read(12'h108, "R3 sys ns");
    do_read(12'h124, "R3 bus sec hi");
    do_read(12'h218, "R3 port0 tx sec lo");
    do_read(12'h2BC, "R3 disabled port1 rx sec hi holds");
    do_read(12'h334, "R3 port2 rx ns");
    // R4 stability: inputs change, snapshot does not
    do_read(12'h104, "R4 sys sec hi stable");
    do_read(12'h2B8, "R4 port1 untouched");
    // R10 write to read-only and unmapped
    do_write(12'h100, 32'hDEAD_BEEF, 1'b0);
    do_read(12'h100, "R10 ro write ignored");
    do_write(12'h0FC, 32'hFFFF_FFFF, 1'b0);
    do_read(12'h0FC, "R10 unmapped reads 0");
    do_read(12'h418, "R10 port beyond NPORT reads 0");
    // R5 / R6 interrupt
    do_write(12'h008, 32'h1, 1'b1);
    do_read(12'h00C, "R5 pps sets status");
    do_write(12'h00C, 32'h0, 1'b0);
    do_read(12'h00C, "R5 write 0 keeps status");
    do_write(12'h00C, 32'h1, 1'b1);
    do_read(12'h00C, "R5 set beats clear");
    do_write(12'h00C, 32'h1, 1'b0);
    do_read(12'h00C, "R5 clear by 1");
    // R7 loads
    do_write(12'h01C, 32'h3, 1'b0);
    do_write(12'h01C, 32'h2, 1'b0);
    do_read(12'h01C, "R7 load reads 0");
    // R8 values
    do_write(12'h014, 32'hFFFF_ABCD, 1'b0);
    do_read(12'h014, "R8 sec hi masked");
    do_write(12'h030, 32'hFFFF_FFFF, 1'b0);
    do_read(12'h030, "R8 offset ns masked");
    // R9 period
    do_write(12'h130, 32'h1234_5678, 1'b0);
    do_write(12'h134, 32'h0000_0003, 1'b0);
    do_read(12'h130, "R9 period lo reads 0");
    do_read(12'h134, "R9 period hi reads 0");
    // random mix
    for (int n = 0; n < 500; n++) begin
      int unsigned r = $urandom;
      logic [11:0] a = pick_addr($urandom, $urandom);
      if (r % 3 == 0) do_read(a, "R10 random readback");
      else            do_write(a, $urandom, ($urandom % 8) == 0);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule